// File: doc/BRIEF.md
# Nibble-Loaded Cartridge Bank Mapper

This block sits between an 8-bit CPU, a video controller and the two ROMs of a cartridge. It widens addresses on both buses. CPU accesses fall into four 8 KB program windows. The first three windows use software-selected program banks, and the top window is tied to the last program bank. Video pattern fetches fall into eight 1 KB windows, and each has its own character bank. The block also holds the nametable mirroring selection.

The CPU writes eleven 8-bit bank registers in the upper half of its address space. Each register is loaded four bits at a time. A write to the even address of a register's pair fills the low half, and a write to the odd address fills the high half. Only the low four data bits are used. The mapped addresses are combinational from the present register contents, so a new bank takes effect on the cycle after the write edge.

Top module: `nibble_bank_mapper`

## Requirements
- R1: A write to the even address of a pair sets bits 3:0 of that bank register to cpu_data[3:0]. Bits 7:4 stay unchanged.
- R2: A write to the odd address of a pair sets bits 7:4 of that bank register to cpu_data[3:0]. Bits 3:0 stay unchanged, and cpu_data[7:4] never reaches any register.
- R3: Pairs 0x8000/0x8001, 0x8002/0x8003 and 0x9000/0x9001 select the program banks of the windows at 0x8000, 0xA000 and 0xC000. The window is cpu_addr[14:13], and prg_addr = {bank, cpu_addr[12:0]}.
- R4: The window at 0xE000 (cpu_addr[14:13] = 3) always uses bank number PRG_BANKS-1.
- R5: Pairs 0xA000/1, 0xA002/3, 0xB000/1, 0xB002/3, 0xC000/1, 0xC002/3, 0xD000/1 and 0xD002/3 select the character banks of pattern windows 0 to 7. The window is ppu_addr[12:10], and chr_addr = {bank, ppu_addr[9:0]}.
- R6: After reset, every bank register is zero except the 0xC000 window's program register, which holds PRG_BANKS-2. After reset, mirror_mode is 0.
- R7: A write to 0xF002 sets mirror_mode from cpu_data[1:0]. The value 0 gives 0 (horizontal), 1 gives 1 (vertical), and 2 or 3 give 2 (four-screen). mirror_mode changes on no other write.
- R8: Decoding compares all 16 address bits. A write to any other address, or an access with cpu_we low, changes no bank register and does not change mirror_mode.
- R9: Bank numbers wrap modulo the bank count. Only the low PRG_BANK_BITS or CHR_BANK_BITS bits of a register reach the address output.
- R10: prg_addr and chr_addr follow cpu_addr and ppu_addr in the same cycle. A register write shows on the outputs from the clock edge that captures it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_data | input | 8 | CPU write data |
| cpu_we | input | 1 | CPU write strobe, sampled at the clock edge |
| ppu_addr | input | 13 | Video pattern-table address |
| prg_addr | output | PRG_BANK_BITS+13 | Program ROM address |
| chr_addr | output | CHR_BANK_BITS+10 | Character ROM address |
| mirror_mode | output | 2 | 0 horizontal, 1 vertical, 2 four-screen |

## Verification
The hardest case to show from the ports is a half-register write that must leave the other half untouched. A register that still reads zero cannot reveal a clobbered half. The stimulus therefore first loads distinct nonzero values into both halves of every character register. It then overwrites one half with data whose upper four bits are all ones, and reads the register back through its pattern window. Near-miss addresses (a different low address bit, a different 4 KB region, or cpu_we held low) are also driven over fully loaded registers. A program value above the bank count shows the modulo wrap.

// File: rtl/nbm_pkg.sv
package nbm_pkg;
    localparam int NUM_PRG_REGS = 3;
    localparam int NUM_CHR_REGS = 8;
    localparam int NUM_REGS     = NUM_PRG_REGS + NUM_CHR_REGS;
    localparam int BANK_W       = 8;
    localparam int IDX_W        = 4;

    typedef enum logic [1:0] {
        MIR_HORZ = 2'd0,
        MIR_VERT = 2'd1,
        MIR_FOUR = 2'd2
    } mirror_e;

    typedef struct packed {
        logic             valid;
        logic [IDX_W-1:0] idx;
        logic             hi;
    } reg_wr_t;

    typedef struct packed {
        logic       valid;
        logic [1:0] sel;
    } mir_wr_t;

    typedef logic [NUM_REGS-1:0][BANK_W-1:0] bank_arr_t;

    typedef struct packed {
        bank_arr_t bank;
        mirror_e   mir;
    } state_t;
endpackage

// File: rtl/nbm_wr_decode.sv
module nbm_wr_decode
    import nbm_pkg::*;
(
    input  logic [15:0] cpu_addr,
    input  logic [1:0]  sel_bits,
    input  logic        cpu_we,
    output reg_wr_t     reg_wr,
    output mir_wr_t     mir_wr
);
    logic [3:0] region;
    logic       row_zero;
    logic       slot;

    always_comb begin
        region   = cpu_addr[15:12];
        row_zero = (cpu_addr[11:2] == 10'd0);
        slot     = cpu_addr[1];
        reg_wr   = '0;
        mir_wr   = '0;
        if (cpu_we && row_zero) begin
            case (region)
                4'h8: begin
                    reg_wr.valid = 1'b1;
                    reg_wr.idx   = {3'b000, slot};
                    reg_wr.hi    = cpu_addr[0];
                end
                4'h9: begin
                    if (!slot) begin
                        reg_wr.valid = 1'b1;
                        reg_wr.idx   = 4'd2;
                        reg_wr.hi    = cpu_addr[0];
                    end
                end
                4'hA, 4'hB, 4'hC, 4'hD: begin
                    reg_wr.valid = 1'b1;
                    reg_wr.idx   = 4'd3 + {region[2:0] - 3'd2, slot};
                    reg_wr.hi    = cpu_addr[0];
                end
                4'hF: begin
                    if (cpu_addr[1:0] == 2'b10) begin
                        mir_wr.valid = 1'b1;
                        mir_wr.sel   = sel_bits;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/nbm_bank_regs.sv
module nbm_bank_regs
    import nbm_pkg::*;
#(
    parameter int PRG_BANK_BITS = 5
) (
    input  logic        clk,
    input  logic        rst_n,
    input  reg_wr_t     reg_wr,
    input  mir_wr_t     mir_wr,
    input  logic [7:0]  wdata,
    output bank_arr_t   bank,
    output mirror_e     mirror
);
    localparam int PRG_BANKS = 1 << PRG_BANK_BITS;
    localparam logic [BANK_W-1:0] PENULT_BANK = BANK_W'(PRG_BANKS - 2);
    localparam logic [7:0] LO_KEEP = 8'h0F;
    localparam logic [7:0] HI_KEEP = 8'hF0;

    function automatic state_t reset_state();
        state_t s;
        s.bank    = '0;
        s.bank[2] = PENULT_BANK;
        s.mir     = MIR_HORZ;
        return s;
    endfunction

    localparam state_t RST_STATE = reset_state();

    state_t      st_d, st_q;
    logic [7:0]  nib_d;

    always_comb begin
        st_d  = st_q;
        nib_d = wdata & LO_KEEP;
        if (reg_wr.valid) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                if (reg_wr.idx == IDX_W'(i)) begin
                    if (reg_wr.hi)
                        st_d.bank[i] = (st_q.bank[i] & LO_KEEP) | (nib_d << 4);
                    else
                        st_d.bank[i] = (st_q.bank[i] & HI_KEEP) | nib_d;
                end
            end
        end
        if (mir_wr.valid) begin
            case (mir_wr.sel)
                2'd0:    st_d.mir = MIR_HORZ;
                2'd1:    st_d.mir = MIR_VERT;
                default: st_d.mir = MIR_FOUR;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RST_STATE;
        else        st_q <= st_d;
    end

    assign bank   = st_q.bank;
    assign mirror = st_q.mir;
endmodule

// File: rtl/nbm_window_map.sv
module nbm_window_map #(
    parameter int WINDOWS   = 8,
    parameter int SEL_W     = 3,
    parameter int BANK_BITS = 8,
    parameter int OFFS_W    = 10
) (
    input  logic [WINDOWS-1:0][7:0]          win_bank,
    input  logic [SEL_W+OFFS_W-1:0]          vaddr,
    output logic [BANK_BITS+OFFS_W-1:0]      paddr
);
    logic [WINDOWS-1:0][BANK_BITS-1:0] wrapped;
    logic [SEL_W-1:0]                  sel;

    for (genvar w = 0; w < WINDOWS; w++) begin : g_wrap
        assign wrapped[w] = win_bank[w][BANK_BITS-1:0];
    end

    always_comb begin
        sel   = vaddr[SEL_W+OFFS_W-1:OFFS_W];
        paddr = {wrapped[sel], vaddr[OFFS_W-1:0]};
    end
endmodule

// File: rtl/nibble_bank_mapper.sv
module nibble_bank_mapper
    import nbm_pkg::*;
#(
    parameter int PRG_BANK_BITS = 5,
    parameter int CHR_BANK_BITS = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [15:0]                 cpu_addr,
    input  logic [7:0]                  cpu_data,
    input  logic                        cpu_we,
    input  logic [12:0]                 ppu_addr,
    output logic [PRG_BANK_BITS+12:0]   prg_addr,
    output logic [CHR_BANK_BITS+9:0]    chr_addr,
    output logic [1:0]                  mirror_mode
);
    localparam int PRG_BANKS   = 1 << PRG_BANK_BITS;
    localparam int PRG_WINDOWS = 4;

    reg_wr_t   reg_wr;
    mir_wr_t   mir_wr;
    bank_arr_t bank_cur;
    mirror_e   mirror_cur;

    logic [PRG_WINDOWS-1:0][7:0]  prg_win;
    logic [NUM_CHR_REGS-1:0][7:0] chr_win;

    nbm_wr_decode u_dec (
        .cpu_addr (cpu_addr),
        .sel_bits (cpu_data[1:0]),
        .cpu_we   (cpu_we),
        .reg_wr   (reg_wr),
        .mir_wr   (mir_wr)
    );

    nbm_bank_regs #(.PRG_BANK_BITS(PRG_BANK_BITS)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .reg_wr (reg_wr),
        .mir_wr (mir_wr),
        .wdata  (cpu_data),
        .bank   (bank_cur),
        .mirror (mirror_cur)
    );

    for (genvar p = 0; p < NUM_PRG_REGS; p++) begin : g_prg
        assign prg_win[p] = bank_cur[p];
    end
    assign prg_win[PRG_WINDOWS-1] = 8'(PRG_BANKS - 1);

    for (genvar c = 0; c < NUM_CHR_REGS; c++) begin : g_chr
        assign chr_win[c] = bank_cur[NUM_PRG_REGS + c];
    end

    nbm_window_map #(
        .WINDOWS(PRG_WINDOWS), .SEL_W(2), .BANK_BITS(PRG_BANK_BITS), .OFFS_W(13)
    ) u_prg_map (
        .win_bank (prg_win),
        .vaddr    (cpu_addr[14:0]),
        .paddr    (prg_addr)
    );

    nbm_window_map #(
        .WINDOWS(NUM_CHR_REGS), .SEL_W(3), .BANK_BITS(CHR_BANK_BITS), .OFFS_W(10)
    ) u_chr_map (
        .win_bank (chr_win),
        .vaddr    (ppu_addr),
        .paddr    (chr_addr)
    );

    assign mirror_mode = mirror_cur;
endmodule

// File: rtl/nbm_checker.sv
module nbm_checker #(
    parameter int PRG_BANK_BITS = 5,
    parameter int CHR_BANK_BITS = 8
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [15:0]                 cpu_addr,
    input logic [7:0]                  cpu_data,
    input logic                        cpu_we,
    input logic [12:0]                 ppu_addr,
    input logic [PRG_BANK_BITS+12:0]   prg_addr,
    input logic [CHR_BANK_BITS+9:0]    chr_addr,
    input logic [1:0]                  mirror_mode,
    input logic [87:0]                 bank_flat
);
    localparam int PRG_BANKS = 1 << PRG_BANK_BITS;
    localparam logic [87:0] RST_FLAT = 88'(PRG_BANKS - 2) << 16;

    // R1: low half of character register 0 follows data, high half holds
    p_low_nibble_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_we && cpu_addr == 16'hA000) |=>
        (bank_flat[27:24] == $past(cpu_data[3:0]) && bank_flat[31:28] == $past(bank_flat[31:28])));

    // R2: high half of character register 0 follows data, low half holds
    p_high_nibble_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_we && cpu_addr == 16'hA001) |=>
        (bank_flat[31:28] == $past(cpu_data[3:0]) && bank_flat[27:24] == $past(bank_flat[27:24])));

    // R3: window at 0x8000 uses program register 0
    p_prg_window0_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[14:13] == 2'd0) |->
        (prg_addr == {bank_flat[PRG_BANK_BITS-1:0], cpu_addr[12:0]}));

    // R4: window at 0xE000 fixed to the last bank
    p_fixed_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[14:13] == 2'd3) |->
        (prg_addr[PRG_BANK_BITS+12:13] == PRG_BANK_BITS'(PRG_BANKS - 1)));

    // R5: pattern window 0 uses character register 0
    p_chr_window0_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ppu_addr[12:10] == 3'd0) |->
        (chr_addr == {bank_flat[24 +: CHR_BANK_BITS], ppu_addr[9:0]}));

    // R6: values right after reset release
    p_reset_vals_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (bank_flat == RST_FLAT && mirror_mode == 2'd0));

    // R7: mirroring only moves on a write to its address
    p_mirror_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_we && cpu_addr == 16'hF002) |=> $stable(mirror_mode));

    // R7: codes 2 and 3 both give four-screen
    p_mirror_four_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_we && cpu_addr == 16'hF002 && cpu_data[1]) |=> (mirror_mode == 2'd2));

    // R8: near-miss address leaves registers untouched
    p_stray_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_we && cpu_addr == 16'h8004) |=> $stable(bank_flat));

    // R8: no write strobe, no change
    p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_we |=> ($stable(bank_flat) && $stable(mirror_mode)));
endmodule

bind nibble_bank_mapper nbm_checker #(
    .PRG_BANK_BITS(PRG_BANK_BITS),
    .CHR_BANK_BITS(CHR_BANK_BITS)
) u_nbm_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cpu_addr    (cpu_addr),
    .cpu_data    (cpu_data),
    .cpu_we      (cpu_we),
    .ppu_addr    (ppu_addr),
    .prg_addr    (prg_addr),
    .chr_addr    (chr_addr),
    .mirror_mode (mirror_mode),
    .bank_flat   (bank_cur)
);

// File: tb/tb_nibble_bank_mapper.sv
module tb_nibble_bank_mapper;
    localparam int CLK_PERIOD = 10;
    localparam int PB = 5;
    localparam int CB = 8;
    localparam int PRG_BANKS = 1 << PB;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [15:0]       cpu_addr = '0;
    logic [7:0]        cpu_data = '0;
    logic              cpu_we = 1'b0;
    logic [12:0]       ppu_addr = '0;
    logic [PB+12:0]    prg_addr;
    logic [CB+9:0]     chr_addr;
    logic [1:0]        mirror_mode;

    nibble_bank_mapper #(.PRG_BANK_BITS(PB), .CHR_BANK_BITS(CB)) dut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
        .cpu_we(cpu_we), .ppu_addr(ppu_addr), .prg_addr(prg_addr),
        .chr_addr(chr_addr), .mirror_mode(mirror_mode)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        int          kind;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t       sb[$];
    int          checks = 0;
    int          errors = 0;
    logic [7:0]  m_bank [11];
    logic [1:0]  m_mir;
    bit          done = 0;

    function automatic int idx_of(input logic [15:0] a);
        case (a)
            16'h8000, 16'h8001: return 0;
            16'h8002, 16'h8003: return 1;
            16'h9000, 16'h9001: return 2;
            16'hA000, 16'hA001: return 3;
            16'hA002, 16'hA003: return 4;
            16'hB000, 16'hB001: return 5;
            16'hB002, 16'hB003: return 6;
            16'hC000, 16'hC001: return 7;
            16'hC002, 16'hC003: return 8;
            16'hD000, 16'hD001: return 9;
            16'hD002, 16'hD003: return 10;
            default:            return -1;
        endcase
    endfunction

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        int i;
        @(posedge clk); #1;
        cpu_addr = a; cpu_data = d; cpu_we = 1'b1;
        i = idx_of(a);
        if (i >= 0) begin
            if (a[0]) m_bank[i][7:4] = d[3:0];
            else      m_bank[i][3:0] = d[3:0];
        end
        if (a == 16'hF002) m_mir = (d[1:0] == 2'd0) ? 2'd0 : (d[1:0] == 2'd1) ? 2'd1 : 2'd2;
    endtask

    task automatic idle(input logic [15:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        cpu_addr = a; cpu_data = d; cpu_we = 1'b0;
    endtask

    task automatic chk_prg(input logic [15:0] a, input string tag);
        item_t it;
        logic [7:0] b;
        @(posedge clk); #1;
        cpu_addr = a; cpu_we = 1'b0;
        b = (a[14:13] == 2'd3) ? 8'(PRG_BANKS - 1) : m_bank[a[14:13]];
        it.kind = 0;
        it.exp  = 32'({b[PB-1:0], a[12:0]});
        it.tag  = tag;
        sb.push_back(it);
    endtask

    task automatic chk_chr(input logic [12:0] v, input string tag);
        item_t it;
        @(posedge clk); #1;
        ppu_addr = v; cpu_we = 1'b0;
        it.kind = 1;
        it.exp  = 32'({m_bank[3 + v[12:10]][CB-1:0], v[9:0]});
        it.tag  = tag;
        sb.push_back(it);
    endtask

    task automatic chk_mir(input string tag);
        item_t it;
        @(posedge clk); #1;
        cpu_we = 1'b0;
        it.kind = 2;
        it.exp  = 32'(m_mir);
        it.tag  = tag;
        sb.push_back(it);
    endtask

    task automatic chk_all_chr(input string tag);
        for (int w = 0; w < 8; w++) chk_chr(13'((w << 10) | (w * 37 + 5)), tag);
    endtask

    initial begin
        item_t it;
        logic [31:0] act;
        forever begin
            @(negedge clk);
            if (sb.size() > 0) begin
                it = sb.pop_front();
                case (it.kind)
                    0:       act = 32'(prg_addr);
                    1:       act = 32'(chr_addr);
                    default: act = 32'(mirror_mode);
                endcase
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
                end
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 11; i++) m_bank[i] = 8'h00;
        m_bank[2] = 8'(PRG_BANKS - 2);
        m_mir = 2'd0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R6 reset state, R4 fixed top window
        chk_prg(16'h8123, "R6 prg window 0");
        chk_prg(16'hA456, "R6 prg window 1");
        chk_prg(16'hC789, "R6 prg window 2");
        chk_prg(16'hE001, "R4 fixed window");
        chk_all_chr("R6 chr reset");
        chk_mir("R6 mirror reset");

        // R1 R2 R3 program loads, upper data bits ignored
        wr(16'h8000, 8'hF3);
        wr(16'h8001, 8'hA1);
        wr(16'h8002, 8'h54);
        wr(16'h8003, 8'hE0);
        wr(16'h9000, 8'h07);
        wr(16'h9001, 8'h02);
        chk_prg(16'h9ABC, "R3 window 0 bank");
        chk_prg(16'hA000, "R3 window 1 bank");
        chk_prg(16'hDFFF, "R9 window 2 wraps");
        chk_prg(16'hFFFF, "R4 fixed after loads");
        // R10 same-cycle address follow
        chk_prg(16'h0123, "R10 window 0 low half");

        // R5 character loads
        for (int w = 0; w < 8; w++) begin
            logic [15:0] base;
            base = 16'hA000 + 16'((w / 2) << 12) + 16'((w % 2) * 2);
            wr(base,         8'hF0 | 8'(w + 1));
            wr(base + 16'd1, 8'hF0 | 8'(15 - w));
        end
        chk_all_chr("R5 chr windows");

        // R1: low half rewritten, high half kept
        wr(16'hA000, 8'hFC);
        chk_chr(13'h0155, "R1 low half only");
        // R2: high half rewritten, low half kept
        wr(16'hA003, 8'hF9);
        chk_chr(13'h0400, "R2 high half only");

        // R8 near-miss addresses and no strobe
        wr(16'h8004, 8'hFF);
        wr(16'h9002, 8'hFF);
        wr(16'hA010, 8'hFF);
        wr(16'h8800, 8'hFF);
        wr(16'hE000, 8'hFF);
        wr(16'hF000, 8'hFF);
        wr(16'hF003, 8'h03);
        idle(16'hA000, 8'h0F);
        idle(16'hF002, 8'h02);
        chk_all_chr("R8 chr unchanged");
        chk_prg(16'h8000, "R8 prg 0 unchanged");
        chk_prg(16'hA000, "R8 prg 1 unchanged");
        chk_prg(16'hC000, "R8 prg 2 unchanged");
        chk_mir("R8 mirror unchanged");

        // R7 mirroring codes
        wr(16'hF002, 8'h01); chk_mir("R7 vertical");
        wr(16'hF002, 8'h00); chk_mir("R7 horizontal");
        wr(16'hF002, 8'h02); chk_mir("R7 four-screen code 2");
        wr(16'hF002, 8'hF5); chk_mir("R7 code 1 with upper bits");
        wr(16'hF002, 8'h03); chk_mir("R7 four-screen code 3");

        // R9 high nibble beyond bank count wraps
        wr(16'h8001, 8'h0F);
        chk_prg(16'h8000, "R9 prg window 0 wraps");

        repeat (3) @(posedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule